// File: doc/BRIEF.md
# UART Interrupt Cause and Status Register

This block holds the interrupt state of a serial port. Four cause generators outside the block (line status, receive data available, receive character timeout, transmit space available) pulse or hold an event line. A fifth cause, modem status, is raised inside the block whenever one of the four synchronised modem inputs changes level. Every cause latches into its own pending bit, and several can be pending at the same time. The host clears any subset of them by writing the low status byte back, with a one in each bit to clear. There is no priority encoding and no clear on read.

A 32-bit configuration word holds the per-cause enables and six modem-control outputs. One level-sensitive interrupt line is high while any enabled cause is pending. The 24-bit status word combines the pending causes, the modem byte (delta flags and current levels) and the line-status byte supplied by the receiver. The host interfaces are plain write strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `uart_irq_stat`

## Requirements
- R1: After reset the status word reads 0 in its pending and modem fields, the configuration word reads 0, the interrupt is low and all six modem-control outputs are low.
- R2: An event input high at a clock edge sets its pending bit, visible from that edge on: evt_i[0] sets status bit 0 (line status), evt_i[1] sets bit 1 (data available), evt_i[2] sets bit 2 (character timeout), evt_i[3] sets bit 3 (transmit space).
- R3: A pending bit stays set while no clear is written for it, whatever other causes do, so several bits can be pending together.
- R4: A status byte write clears each pending bit [4:0] whose written bit is 1 and leaves the other pending bits unchanged. Written bits [7:5] have no effect, and status bits [7:5] always read 0.
- R5: When a cause's set and its clear arrive in the same cycle, the cause stays pending.
- R6: Each modem input (index 0 CTS, 1 DSR, 2 RI, 3 DCD) passes through a two-flop synchroniser. Its synchronised level appears at status bit 12+i two edges after the change. Any rising or falling edge of that level sets the delta flag at status bit 8+i one edge later, and in the same cycle sets the modem-status pending bit 4.
- R7: Clearing pending bit 4 also clears all four delta flags. Writes that do not clear bit 4 leave the delta flags unchanged.
- R8: A configuration write stores the whole 32-bit word, which reads back on cfg_o from the next cycle. Bits 24 to 29 drive, in order, dtr_o, rts_o, out1_o, out2_o, loop_o and flow_o.
- R9: irq_o is high exactly when an enabled cause is pending. Configuration bit 0 enables data available and character timeout, bit 1 enables transmit space, bit 2 enables line status, and bit 3 enables modem status.
- R10: Status bits [23:16] show lsr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Cause events: line, data available, timeout, transmit space |
| lsr_i | input | 8 | Line-status byte from the receiver/transmitter |
| modem_i | input | 4 | Asynchronous modem inputs CTS, DSR, RI, DCD |
| stat_wr_i | input | 1 | Status byte write strobe |
| stat_wdata_i | input | 8 | Status byte write data, ones clear causes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| stat_o | output | 24 | Status word: pending, modem byte, line byte |
| cfg_o | output | 32 | Configuration word |
| irq_o | output | 1 | Level interrupt |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| out1_o | output | 1 | User output 1 |
| out2_o | output | 1 | User output 2 |
| loop_o | output | 1 | Loopback select |
| flow_o | output | 1 | Hardware RTS/CTS flow control enable |

## Verification
The assertions assume that the modem inputs are low while reset is held. Otherwise the first synchronised level would count as an edge. They also assume that event inputs and write strobes are driven synchronously. The bench changes every input half a cycle away from the active edge and keeps the modem lines low through reset. It waits the full synchroniser latency before it expects a modem change to appear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_EVT    = 4;
  localparam int unsigned NUM_CAUSE  = NUM_EVT + 1;
  localparam int unsigned NUM_MODEM  = 4;
  localparam int unsigned CFG_W      = 32;

  // pending bit positions (decoded by the host)
  localparam int unsigned C_LINE = 0;
  localparam int unsigned C_RDA  = 1;
  localparam int unsigned C_TMO  = 2;
  localparam int unsigned C_TXS  = 3;
  localparam int unsigned C_MDM  = 4;

  // enable bit positions in the configuration word
  localparam int unsigned EN_RDA  = 0;
  localparam int unsigned EN_TXS  = 1;
  localparam int unsigned EN_LINE = 2;
  localparam int unsigned EN_MDM  = 3;
  localparam int unsigned EN_W    = 4;

  // first modem-control output bit
  localparam int unsigned CTL_LO = 24;
  localparam int unsigned CTL_W  = 6;
endpackage

// File: rtl/uis_cause_latch.sv
module uis_cause_latch #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[k] <= 1'b0;
      else        pend_o[k] <= set_i[k] | (pend_o[k] & ~clr_i[k]);
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> pend_o[k]);
    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    // R3
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[k] && !clr_i[k]) |=> pend_o[k]);
  end
endmodule

// File: rtl/uis_modem_track.sv
module uis_modem_track #(
  parameter int unsigned LINES  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  input  logic             clr_i,
  output logic [LINES-1:0] cur_o,
  output logic [LINES-1:0] delta_o,
  output logic             any_edge_o
);
  logic [STAGES-1:0][LINES-1:0] sync_q;
  logic [LINES-1:0]             prev_q;
  logic [LINES-1:0]             edge_w;

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign cur_o      = sync_q[STAGES-1];
  assign edge_w     = cur_o ^ prev_q;
  assign any_edge_o = |edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_o <= '0;
    end else begin
      prev_q  <= cur_o;
      delta_o <= edge_w | (clr_i ? '0 : delta_o);
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R6
    rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cur_o[i]) |=> delta_o[i]);
    // R6
    fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cur_o[i]) |=> delta_o[i]);
  end
  // R7
  delta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !any_edge_o) |=> (delta_o == '0));
  // R7
  delta_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((delta_o & $past(delta_o)) == $past(delta_o)));
endmodule

// File: rtl/uis_irq_gate.sv
module uis_irq_gate
  import uart_irq_pkg::*;
(
  input  logic [NUM_CAUSE-1:0] pend_i,
  input  logic [EN_W-1:0]      en_i,
  output logic                 irq_o
);
  logic [NUM_CAUSE-1:0] live_w;

  always_comb begin
    live_w         = '0;
    live_w[C_LINE] = pend_i[C_LINE] & en_i[EN_LINE];
    live_w[C_RDA]  = pend_i[C_RDA]  & en_i[EN_RDA];
    live_w[C_TMO]  = pend_i[C_TMO]  & en_i[EN_RDA];
    live_w[C_TXS]  = pend_i[C_TXS]  & en_i[EN_TXS];
    live_w[C_MDM]  = pend_i[C_MDM]  & en_i[EN_MDM];
  end

  assign irq_o = |live_w;

  // R9
  always_comb irq_needs_pend_chk: assert (!irq_o || (|pend_i));
  // R9
  always_comb tmo_uses_rda_en_chk: assert (!(pend_i[C_TMO] && en_i[EN_RDA]) || irq_o);
endmodule

// File: rtl/uart_irq_stat.sv
module uart_irq_stat
  import uart_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic [7:0]           lsr_i,
  input  logic [NUM_MODEM-1:0] modem_i,
  input  logic                 stat_wr_i,
  input  logic [7:0]           stat_wdata_i,
  input  logic                 cfg_wr_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  output logic [23:0]          stat_o,
  output logic [CFG_W-1:0]     cfg_o,
  output logic                 irq_o,
  output logic                 dtr_o,
  output logic                 rts_o,
  output logic                 out1_o,
  output logic                 out2_o,
  output logic                 loop_o,
  output logic                 flow_o
);
  localparam int unsigned PAD_W = 8 - NUM_CAUSE;

  logic [NUM_CAUSE-1:0] clr_w, set_w, pend_w;
  logic [NUM_MODEM-1:0] cur_w, delta_w;
  logic                 mdm_edge_w;
  logic [CFG_W-1:0]     cfg_q;
  logic                 unused_wbits;

  assign unused_wbits = ^stat_wdata_i[7:NUM_CAUSE];
  assign clr_w = stat_wr_i ? stat_wdata_i[NUM_CAUSE-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
  end

  uis_modem_track #(.LINES(NUM_MODEM), .STAGES(SYNC_STAGES)) u_modem (
    .clk(clk), .rst_n(rst_n), .pin_i(modem_i), .clr_i(clr_w[C_MDM]),
    .cur_o(cur_w), .delta_o(delta_w), .any_edge_o(mdm_edge_w)
  );

  assign set_w = {mdm_edge_w, evt_i};

  uis_cause_latch #(.N(NUM_CAUSE)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .pend_o(pend_w)
  );

  uis_irq_gate u_gate (
    .pend_i(pend_w), .en_i(cfg_q[EN_W-1:0]), .irq_o(irq_o)
  );

  assign stat_o = {lsr_i, cur_w, delta_w, {PAD_W{1'b0}}, pend_w};
  assign cfg_o  = cfg_q;
  assign {flow_o, loop_o, out2_o, out1_o, rts_o, dtr_o} = cfg_q[CTL_LO +: CTL_W];

  // R8
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (cfg_o == $past(cfg_wdata_i)));
  // R6
  mdm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_edge_w |=> (stat_o[C_MDM] && (stat_o[15:8] & 8'h0F) != 8'h00));
endmodule

// File: tb/tb_uart_irq_stat.sv
module tb_uart_irq_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_i = '0;
  logic [7:0]  lsr_i = '0;
  logic [3:0]  modem_i = '0;
  logic        stat_wr_i = 1'b0;
  logic [7:0]  stat_wdata_i = '0;
  logic        cfg_wr_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [23:0] stat_o;
  logic [31:0] cfg_o;
  logic irq_o, dtr_o, rts_o, out1_o, out2_o, loop_o, flow_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_stat dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lsr_i(lsr_i), .modem_i(modem_i),
    .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i), .cfg_wr_i(cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i), .stat_o(stat_o), .cfg_o(cfg_o), .irq_o(irq_o),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .flow_o(flow_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // fields: evt[21:18] en[17:14] clr[13:6] pend[5:1] irq[0]
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 8'h00, 5'b00001, 1'b0},
    {4'b0010, 4'b0100, 8'h00, 5'b00011, 1'b1},
    {4'b0000, 4'b0000, 8'h01, 5'b00010, 1'b0},
    {4'b0100, 4'b0001, 8'h02, 5'b00100, 1'b1},
    {4'b1000, 4'b0010, 8'hE0, 5'b01100, 1'b1},
    {4'b1000, 4'b0000, 8'h08, 5'b01100, 1'b0},
    {4'b0000, 4'b1000, 8'h0C, 5'b00000, 1'b0},
    {4'b1111, 4'b1111, 8'h1F, 5'b01111, 1'b1},
    {4'b0000, 4'b0001, 8'h00, 5'b01111, 1'b1},
    {4'b0000, 4'b0000, 8'h0F, 5'b00000, 1'b0}
  };

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk("R1 status", {8'h0, stat_o}, 32'h0);
    chk("R1 cfg", cfg_o, 32'h0);
    chk("R1 irq/ctl", {26'h0, irq_o, dtr_o, rts_o, out1_o, out2_o, loop_o, flow_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R9: vector walk
    for (int v = 0; v < NV; v++) begin
      evt_i        = VEC[v][21:18];
      cfg_wr_i     = 1'b1;
      cfg_wdata_i  = {28'h0, VEC[v][17:14]};
      stat_wr_i    = 1'b1;
      stat_wdata_i = VEC[v][13:6];
      @(negedge clk);
      evt_i = '0; cfg_wr_i = 1'b0; stat_wr_i = 1'b0; stat_wdata_i = '0;
      chk($sformatf("R2 R3 R4 R5 pend v%0d", v), {27'h0, stat_o[4:0]}, {27'h0, VEC[v][5:1]});
      chk($sformatf("R9 irq v%0d", v), {31'h0, irq_o}, {31'h0, VEC[v][0]});
      chk($sformatf("R4 pad v%0d", v), {29'h0, stat_o[7:5]}, 32'h0);
    end

    // R10 line status byte shows through
    lsr_i = 8'hA5;
    #1;
    chk("R10 lsr", {24'h0, stat_o[23:16]}, 32'hA5);
    lsr_i = 8'h00;

    // R6 modem rising edge on CTS
    cfg_wr_i = 1'b1; cfg_wdata_i = 32'h0000_0008;
    modem_i = 4'b0001;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R6 not yet", {16'h0, stat_o[15:8], 3'b0, stat_o[4:0]}, 32'h0);
    @(negedge clk);
    chk("R6 level", {24'h0, stat_o[15:8]}, 32'h10);
    chk("R6 no irq yet", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R6 delta", {24'h0, stat_o[15:8]}, 32'h11);
    chk("R6 cause", {27'h0, stat_o[4:0]}, 32'h10);
    chk("R9 modem irq", {31'h0, irq_o}, 32'h1);

    // R7 write without bit 4 keeps delta
    stat_wr_i = 1'b1; stat_wdata_i = 8'h0F;
    @(negedge clk);
    stat_wr_i = 1'b0;
    chk("R7 keep", {24'h0, stat_o[15:8]}, 32'h11);
    // R7 clear bit 4 clears delta
    stat_wr_i = 1'b1; stat_wdata_i = 8'h10;
    @(negedge clk);
    stat_wr_i = 1'b0;
    chk("R7 clear", {24'h0, stat_o[15:8], 3'b0, stat_o[4:0]}, 32'h1000);
    chk("R9 irq off", {31'h0, irq_o}, 32'h0);

    // R6 falling edge on CTS, rising on DCD
    modem_i = 4'b1000;
    repeat (3) @(negedge clk);
    chk("R6 fall/rise delta", {24'h0, stat_o[15:8]}, 32'h89);
    chk("R6 fall cause", {27'h0, stat_o[4:0]}, 32'h10);

    // R8 configuration and control outputs
    cfg_wr_i = 1'b1; cfg_wdata_i = 32'h2A00_0000;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R8 cfg", cfg_o, 32'h2A00_0000);
    chk("R8 ctl", {26'h0, dtr_o, rts_o, out1_o, out2_o, loop_o, flow_o}, 32'b010101);
    chk("R9 masked", {31'h0, irq_o}, 32'h0);

    finish_run();
  end
endmodule